// File: doc/BRIEF.md
# Secondary-Cache Tag and Dirty-Status Controller

This block sits between a host bus interface and an external tag RAM for a secondary cache. It sequences the tag RAM's output enable during copy-back tag reads, so that the RAM places the indexed tag on the address bus for two or three clocks and then lets the bus float. It also samples the dirty status that the tag RAM returns a programmable number of clocks after a transfer start. During tag writes it drives the new line status onto a dirty-out pin whose active level is set by configuration.

The three cache pins also have a second use. When the second-processor mode is selected, the cache sequencing stops, the dirty-in pin becomes a bus request that is passed to the arbiter, and the dirty-out and output-enable pins carry the arbiter's bus grant and data bus grant.

Top module: `l2_tag_ctl`

## Requirements
- R1: While reset is held, and afterwards with no activity, pin_toe is 0, tag_we is 0, dirty_smp_vld is 0, dirty_smp is 0, and pin_dout is at its negated level. That level is the inverse of cfg_dirty_hi.
- R2: If xfer_start is sampled high at clock edge k, dirty_smp_vld is high for exactly one cycle, the cycle after edge k+cfg_hit_dly+1. This gives a hit delay of 1 to 4 clocks. In that cycle dirty_smp equals pin_din as sampled at that edge. A new xfer_start restarts the count.
- R3: dirty_smp keeps the sampled value until addr_done is sampled high, and is then 0 from the next edge. A sample taken at the same edge takes priority over the clear.
- R4: pin_dout shows a modified line (1) as the level cfg_dirty_hi and an unmodified line (0) as its inverse.
- R5: tag_we is tag_wr_req delayed by one clock. While tag_we is high, the line status driven on pin_dout is line_modified as sampled at the previous edge.
- R6: In the cycle after tag_we falls, pin_dout keeps the value it had in the last write cycle. It then returns to the negated level.
- R7: A copy-back request accepted when idle drives pin_toe high for 2 cycles, or for 3 cycles if cfg_toe_hold3 was 1 when the request was accepted. pin_toe rises in the cycle after the accepting edge.
- R8: Copy-back requests are ignored while a pin_toe pulse runs and for one cycle after it ends. A request that is held high continuously therefore gives pulses separated by exactly 2 low cycles.
- R9: While cfg_mp_mode is 1, pin_toe equals arb_dbg1 and pin_dout equals arb_bg1, and arb_br1 equals pin_din. tag_we, dirty_smp_vld and dirty_smp are 0, and all cache sequencing is cleared. While cfg_mp_mode is 0, arb_br1 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mp_mode | input | 1 | 1 selects the second-processor pin function |
| cfg_dirty_hi | input | 1 | Active level of the dirty-out pin |
| cfg_toe_hold3 | input | 1 | 1 selects a 3-cycle tag output enable, 0 a 2-cycle one |
| cfg_hit_dly | input | HD_W | Hit delay minus one, in clocks |
| xfer_start | input | 1 | Transfer-start strobe |
| addr_done | input | 1 | End of the address phase |
| copyback_req | input | 1 | Request for a copy-back tag read |
| tag_wr_req | input | 1 | Tag write request |
| line_modified | input | 1 | Status to write: 1 modified, 0 unmodified |
| arb_bg1 | input | 1 | Bus grant for the second processor |
| arb_dbg1 | input | 1 | Data bus grant for the second processor |
| pin_din | input | 1 | Dirty-in from the tag RAM, or bus request 1 |
| pin_dout | output | 1 | Dirty-out to the tag RAM, or bus grant 1 |
| pin_toe | output | 1 | Tag output enable, or data bus grant 1 |
| tag_we | output | 1 | Tag RAM write enable |
| dirty_smp_vld | output | 1 | One-cycle pulse: dirty status sampled |
| dirty_smp | output | 1 | Sampled dirty status |
| arb_br1 | output | 1 | Bus request 1 passed to the arbiter |

## Verification
The assertions assume that the configuration inputs do not change while a tag output enable pulse or a hit-delay count is running. The one exception is cfg_mp_mode, whose switch clears all sequencing at once. The random stimulus changes configuration only at low probability, and the bench model reads the same live values as the design, so any change that does occur is checked consistently. Strobes and requests are drawn sparsely enough that pulses complete, and held requests in the directed cases exercise the ignore window.

// File: rtl/l2_tag_ctl.sv
module l2_tag_ctl #(
  parameter int HD_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_mp_mode,
  input  logic            cfg_dirty_hi,
  input  logic            cfg_toe_hold3,
  input  logic [HD_W-1:0] cfg_hit_dly,
  input  logic            xfer_start,
  input  logic            addr_done,
  input  logic            copyback_req,
  input  logic            tag_wr_req,
  input  logic            line_modified,
  input  logic            arb_bg1,
  input  logic            arb_dbg1,
  input  logic            pin_din,
  output logic            pin_dout,
  output logic            pin_toe,
  output logic            tag_we,
  output logic            dirty_smp_vld,
  output logic            dirty_smp,
  output logic            arb_br1
);
  localparam int TC_W = 2;
  localparam logic [TC_W-1:0] LAST_SHORT = TC_W'(1);
  localparam logic [TC_W-1:0] LAST_LONG  = TC_W'(2);

  typedef enum logic [1:0] {T_IDLE, T_DRIVE, T_RECOV} tstate_t;

  logic            tw_q, dq, run_q, vld_q, smp_q, toe_q, hold3_q;
  logic [HD_W-1:0] hcnt;
  logic [TC_W-1:0] tcnt;
  tstate_t         tst;

  wire hit_now  = run_q && (hcnt == cfg_hit_dly);
  wire toe_last = tcnt == (hold3_q ? LAST_LONG : LAST_SHORT);

  assign pin_dout      = cfg_mp_mode ? arb_bg1  : (dq ~^ cfg_dirty_hi);
  assign pin_toe       = cfg_mp_mode ? arb_dbg1 : toe_q;
  assign arb_br1       = cfg_mp_mode & pin_din;
  assign tag_we        = tw_q  & ~cfg_mp_mode;
  assign dirty_smp_vld = vld_q & ~cfg_mp_mode;
  assign dirty_smp     = smp_q & ~cfg_mp_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tw_q <= 1'b0; dq <= 1'b0;
      run_q <= 1'b0; vld_q <= 1'b0; smp_q <= 1'b0; hcnt <= '0;
      toe_q <= 1'b0; hold3_q <= 1'b0; tcnt <= '0; tst <= T_IDLE;
    end else if (cfg_mp_mode) begin
      tw_q <= 1'b0; dq <= 1'b0;
      run_q <= 1'b0; vld_q <= 1'b0; smp_q <= 1'b0; hcnt <= '0;
      toe_q <= 1'b0; hold3_q <= 1'b0; tcnt <= '0; tst <= T_IDLE;
    end else begin
      tw_q <= tag_wr_req;
      if (tag_wr_req)  dq <= line_modified;
      else if (!tw_q)  dq <= 1'b0;

      vld_q <= 1'b0;
      if (xfer_start) begin
        run_q <= 1'b1;
        hcnt  <= '0;
      end else if (hit_now) begin
        run_q <= 1'b0;
        vld_q <= 1'b1;
      end else if (run_q) begin
        hcnt <= hcnt + 1'b1;
      end
      if (!xfer_start && hit_now) smp_q <= pin_din;
      else if (addr_done)         smp_q <= 1'b0;

      case (tst)
        T_IDLE: if (copyback_req) begin
          tst <= T_DRIVE; toe_q <= 1'b1; tcnt <= '0; hold3_q <= cfg_toe_hold3;
        end
        T_DRIVE: if (toe_last) begin
          tst <= T_RECOV; toe_q <= 1'b0;
        end else begin
          tcnt <= tcnt + 1'b1;
        end
        default: tst <= T_IDLE;
      endcase
    end
  end

  p_vld_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);

  p_toe_min_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_mp_mode && $past(!cfg_mp_mode) && $fell(toe_q)) |-> $past(toe_q, 2));

  p_toe_max_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (toe_q && $past(toe_q) && $past(toe_q, 2)) |=> !toe_q);

  p_toe_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(toe_q) |=> !toe_q);

  p_dout_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_mp_mode && $past(!cfg_mp_mode) && $fell(tw_q)) |-> $stable(dq));

  p_mp_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mp_mode && $past(cfg_mp_mode)) |-> !(vld_q || toe_q || tw_q || run_q));
endmodule

// File: tb/l2_tag_ctl_tb_top.sv
`timescale 1ns/100ps
module l2_tag_ctl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic mp = 0, hi = 1, h3 = 0, xs = 0, ad = 0, cb = 0, tw = 0, lm = 0, bg = 0, dbg = 0, din = 0;
  logic [1:0] hd = 0;
  logic pin_dout, pin_toe, tag_we, vld, smp, br1;
  int checks = 0, errors = 0, cyc = 0;
  logic chk_en = 0;

  always #2 clk = ~clk;

  l2_tag_ctl #(.HD_W(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_mp_mode(mp), .cfg_dirty_hi(hi), .cfg_toe_hold3(h3),
    .cfg_hit_dly(hd), .xfer_start(xs), .addr_done(ad), .copyback_req(cb),
    .tag_wr_req(tw), .line_modified(lm), .arb_bg1(bg), .arb_dbg1(dbg), .pin_din(din),
    .pin_dout(pin_dout), .pin_toe(pin_toe), .tag_we(tag_we), .dirty_smp_vld(vld),
    .dirty_smp(smp), .arb_br1(br1));

  // requirement model
  logic m_tw, m_dq, m_run, m_vld, m_smp, m_toe, m_h3;
  logic [1:0] m_hc, m_tc, m_st;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || mp) begin
      m_tw <= 0; m_dq <= 0; m_run <= 0; m_vld <= 0; m_smp <= 0; m_hc <= 0;
      m_toe <= 0; m_h3 <= 0; m_tc <= 0; m_st <= 0;
    end else begin
      m_tw <= tw;
      m_dq <= tw ? lm : (m_tw ? m_dq : 1'b0);
      m_vld <= 0;
      if (xs) begin m_run <= 1; m_hc <= 0; end
      else if (m_run && m_hc == hd) begin m_run <= 0; m_vld <= 1; end
      else if (m_run) m_hc <= m_hc + 1;
      if (!xs && m_run && m_hc == hd) m_smp <= din;
      else if (ad) m_smp <= 0;
      case (m_st)
        2'd0: if (cb) begin m_st <= 1; m_toe <= 1; m_tc <= 0; m_h3 <= h3; end
        2'd1: if (m_tc == (m_h3 ? 2'd2 : 2'd1)) begin m_st <= 2; m_toe <= 0; end
              else m_tc <= m_tc + 1;
        default: m_st <= 0;
      endcase
    end
  end

  function automatic logic exp_dout(logic q);
    return mp ? bg : (q ~^ hi);
  endfunction
  function automatic logic exp_toe(logic q);
    return mp ? dbg : q;
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (chk_en) begin
      chk("R4/R6 pin_dout", pin_dout, exp_dout(m_dq));
      chk("R7 pin_toe", pin_toe, exp_toe(m_toe));
      chk("R5 tag_we", tag_we, m_tw & ~mp);
      chk("R2 dirty_smp_vld", vld, m_vld & ~mp);
      chk("R3 dirty_smp", smp, m_smp & ~mp);
      chk("R9 arb_br1", br1, mp & din);
    end
  end

  task automatic step(int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic measure_toe(logic hold, output int width, output int gap);
    width = 0; gap = 0;
    h3 = hold; cb = 1;
    step();
    while (!pin_toe) step();
    while (pin_toe) begin width++; step(); end
    while (!pin_toe && gap < 10) begin gap++; step(); end
    cb = 0;
    step(6);
  endtask

  initial begin
    int w, g;
    step(2);
    chk("R1 reset pin_dout", pin_dout, 1'b0);
    chk("R1 reset pin_toe", pin_toe, 1'b0);
    chk("R1 reset tag_we", tag_we, 1'b0);
    chk("R1 reset vld", vld, 1'b0);
    hi = 0; #0.1;
    chk("R1 reset pin_dout low-active", pin_dout, 1'b1);
    hi = 1;
    rst_n = 1; chk_en = 1;
    step(3);

    // R7 / R8 directed
    measure_toe(1'b0, w, g);
    chk("R7 toe width 2", w == 2, 1'b1);
    chk("R8 gap 2", g == 2, 1'b1);
    measure_toe(1'b1, w, g);
    chk("R7 toe width 3", w == 3, 1'b1);
    chk("R8 gap 2 long", g == 2, 1'b1);

    // R2 hit delay 4: sample exactly 4 edges after strobe
    hd = 2'd3; din = 1; xs = 1; step(); xs = 0;
    step(3); chk("R2 no early vld", vld, 1'b0);
    step(); chk("R2 vld at delay 4", vld, 1'b1); chk("R2 sampled value", smp, 1'b1);
    din = 0; step(2); chk("R3 held", smp, 1'b1);
    ad = 1; step(); ad = 0; chk("R3 cleared", smp, 1'b0);

    // R6 hold after write
    tw = 1; lm = 1; step(); tw = 0; lm = 0;
    chk("R5 write level", pin_dout, 1'b1);
    step(); chk("R6 held after we", pin_dout, 1'b1); chk("R6 we low", tag_we, 1'b0);
    step(); chk("R6 negated", pin_dout, 1'b0);

    // R9 directed
    mp = 1; bg = 1; dbg = 0; din = 1; #0.1;
    chk("R9 dout=bg", pin_dout, 1'b1); chk("R9 toe=dbg", pin_toe, 1'b0);
    chk("R9 br1", br1, 1'b1);
    step(3); mp = 0; bg = 0; din = 0; step(3);

    // constrained random
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 4000; i++) begin
      xs  = ($urandom % 8) == 0;
      ad  = ($urandom % 6) == 0;
      cb  = ($urandom % 5) == 0;
      tw  = ($urandom % 3) == 0;
      lm  = $urandom % 2;
      din = $urandom % 2;
      bg  = $urandom % 2;
      dbg = $urandom % 2;
      if (($urandom % 60) == 0) hd = 2'($urandom);
      if (($urandom % 60) == 0) h3 = $urandom % 2;
      if (($urandom % 80) == 0) hi = $urandom % 2;
      if (($urandom % 200) == 0) mp = ~mp;
      step();
    end
    chk_en = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule